// File: doc/BRIEF.md
# Dual message buffer transfer interface

This block sits between a CPU and the shared message object RAM of a CAN-style controller. It gives the CPU two identical interface sets. Each set has six staging buffer registers, one per field of a message object, plus a command mask register and a command request register. The CPU fills or empties the buffers at its own pace. A write of an object number into the request register then moves the fields chosen by the mask between the buffers and that object in RAM, in the direction the mask selects. The CPU never touches the RAM directly, so its accesses cannot collide with the protocol engine's traffic.

The RAM has a single port, and three requesters share it: a protocol-side word port, interface set 0 and interface set 1. A fixed-priority arbiter grants it. Once a set has been granted, it moves one word per clock until its selected fields are done, and only the protocol side can pause it. Each object also carries a new-data flag. It is seen as bit 0 of the status field and can be cleared as a side effect of a read transfer.

Because the two sets are independent, one can be kept for loading objects into RAM and the other for fetching them. A transfer on one set never disturbs the buffers or the pending command of the other.

Top module: `msgbuf_xfer_if`

## Requirements
- R1: After reset, both sets read back zero in every register (busy clear, object 0, mask 0, buffers 0), and cpu_rdata is 0.
- R2: CPU registers 0 to 5 of a set are its buffers for the fields arbitration, control, acceptance mask, data bytes 0 to 3, data bytes 4 to 7 and status. Register 6 is the command mask: bits 5:0 select fields (bit k is buffer k), bit 6 = 1 means buffer to RAM and bit 7 is the clear-new-data option. A buffer to RAM transfer writes buffer k into RAM word (object-1)*6+k for every selected k and leaves the other words of the object unchanged.
- R3: A RAM to buffer transfer (mask bit 6 = 0) loads buffer k from RAM word (object-1)*6+k for every selected k and leaves unselected buffers unchanged.
- R4: Register 7 is the command request register. Writing it with a valid object number in bits 7:0 starts a transfer and sets busy, which reads back in bit 31 with the object number in bits 7:0. Busy clears when the transfer completes, and this includes a transfer with no field selected.
- R5: An object number of 0, or any value above NUM_OBJ, starts nothing. Busy stays clear and the stored object number is kept.
- R6: While a set is busy, CPU writes to any of its registers 0 to 7 are ignored.
- R7: A transfer on one set leaves the other set's buffers and command registers unchanged.
- R8: A protocol-side request gets the RAM port in the same cycle and stalls both sets. When neither set holds the port, set 0 is granted before set 1. A set that has been granted keeps the port, except for protocol cycles, until its selected fields are done.
- R9: Each object has a new-data flag, cleared at reset. ps_nd_set sets it for object ps_nd_obj. A buffer to RAM transfer of the status field loads it from buffer bit 0. A RAM to buffer transfer of the status field returns it in buffer bit 0, with bits 31:1 coming from RAM. A RAM to buffer transfer with mask bit 7 set clears it.
- R10: With no contention, a buffer to RAM transfer of k fields writes one word per clock. Busy, as read through cpu_rdata, reads clear no later than k+2 clock cycles after the request write.
- R11: cpu_rdata shows the register addressed by cpu_set and cpu_reg in the previous cycle. ps_rdata shows the RAM word addressed by a protocol read in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_set | input | 1 | Interface set select (0 or 1) |
| cpu_reg | input | 3 | Register select within the set |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Registered read data of the addressed register |
| ps_req | input | 1 | Protocol-side RAM word access request |
| ps_we | input | 1 | Protocol-side write enable |
| ps_addr | input | AW | Protocol-side RAM word address |
| ps_wdata | input | 32 | Protocol-side write data |
| ps_rdata | output | 32 | RAM read data, valid the cycle after a protocol read |
| ps_nd_set | input | 1 | Set the new-data flag of ps_nd_obj |
| ps_nd_obj | input | 8 | Object number for ps_nd_set |

## Verification
The assertions check the following on every cycle:
- the arbiter never grants a set while the protocol side requests;
- at most one set holds a grant;
- a grant only goes to a busy set;
- a request write to an idle set starts a transfer exactly when its object number is valid.

The field-selective copying is shown only by the bench's scenarios. This covers untouched RAM words and untouched buffers, the new-data flag's path through the status field, writes ignored while busy, set 0 winning after a protocol stall and the one-word-per-clock completion time. The bench shows these by comparing the readback against its own model of RAM, flags and buffers.

// File: rtl/msgbuf_pkg.sv
`timescale 1ns/1ps
package msgbuf_pkg;
  localparam int NSET     = 2;
  localparam int NFLD     = 6;
  localparam int DW       = 32;
  localparam int OBJ_W    = 8;
  localparam int FW       = $clog2(NFLD);
  localparam int REG_MASK = 6;
  localparam int REG_REQ  = 7;
  localparam int MB_DIR   = 6;
  localparam int MB_CLRND = 7;
  localparam int F_STAT   = 5;

  function automatic logic [FW-1:0] first_fld(input logic [NFLD-1:0] m);
    first_fld = '0;
    for (int k = NFLD - 1; k >= 0; k--) begin
      if (m[k]) first_fld = FW'(k);
    end
  endfunction
endpackage

// File: rtl/msgbuf_ram.sv
`timescale 1ns/1ps
module msgbuf_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 96,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/msgbuf_arb.sv
`timescale 1ns/1ps
module msgbuf_arb #(
  parameter int NREQ = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ps_req,
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] gnt
);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic          own_v;
  logic [IW-1:0] own_id;
  logic [IW-1:0] pick;
  logic          pick_v;

  always_comb begin
    pick_v = 1'b0;
    pick   = '0;
    if (own_v && req[own_id]) begin
      pick_v = 1'b1;
      pick   = own_id;
    end else begin
      for (int k = NREQ - 1; k >= 0; k--) begin
        if (req[k]) begin
          pick_v = 1'b1;
          pick   = IW'(k);
        end
      end
    end
    gnt = '0;
    if (pick_v && !ps_req) gnt[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_v  <= 1'b0;
      own_id <= '0;
    end else if (|gnt) begin
      own_v  <= 1'b1;
      own_id <= pick;
    end else if (!ps_req) begin
      own_v  <= 1'b0;
    end
  end
endmodule

// File: rtl/msgbuf_ifset.sv
`timescale 1ns/1ps
module msgbuf_ifset
  import msgbuf_pkg::*;
#(
  parameter int NUM_OBJ = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_we,
  input  logic [2:0]       cpu_reg,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    rd_word,
  input  logic             gnt,
  input  logic [DW-1:0]    ram_rdata,
  input  logic             nd_flag,
  output logic             req,
  output logic [FW-1:0]    cur_fld,
  output logic [OBJ_W-1:0] obj,
  output logic             dir,
  output logic [DW-1:0]    wr_word,
  output logic             clr_nd,
  output logic             busy
);
  logic [DW-1:0]    buf_q [NFLD];
  logic [7:0]       mask_q;
  logic [NFLD-1:0]  rem_q;
  logic [OBJ_W-1:0] obj_q;
  logic             busy_q;
  logic             pend_v;
  logic [FW-1:0]    pend_fld;
  logic             pend_nd;
  logic             done;
  logic             obj_ok;
  logic [OBJ_W-1:0] req_obj;

  assign req_obj = cpu_wdata[OBJ_W-1:0];
  assign obj_ok  = (req_obj != '0) && (req_obj <= OBJ_W'(NUM_OBJ));
  assign cur_fld = first_fld(rem_q);
  assign req     = busy_q && (rem_q != '0);
  assign dir     = mask_q[MB_DIR];
  assign obj     = obj_q;
  assign busy    = busy_q;
  assign wr_word = buf_q[cur_fld];
  assign done    = busy_q && (rem_q == '0) && !pend_v;
  assign clr_nd  = done && mask_q[MB_CLRND] && !mask_q[MB_DIR];

  always_comb begin
    case (cpu_reg)
      3'(REG_MASK): rd_word = {{(DW-8){1'b0}}, mask_q};
      3'(REG_REQ):  rd_word = {busy_q, {(DW-1-OBJ_W){1'b0}}, obj_q};
      default:      rd_word = buf_q[FW'(cpu_reg)];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NFLD; k++) buf_q[k] <= '0;
      mask_q   <= '0;
      rem_q    <= '0;
      obj_q    <= '0;
      busy_q   <= 1'b0;
      pend_v   <= 1'b0;
      pend_fld <= '0;
      pend_nd  <= 1'b0;
    end else begin
      pend_v   <= gnt && !mask_q[MB_DIR];
      pend_fld <= cur_fld;
      pend_nd  <= nd_flag;
      if (gnt) rem_q[cur_fld] <= 1'b0;
      if (pend_v) begin
        if (pend_fld == FW'(F_STAT)) buf_q[pend_fld] <= {ram_rdata[DW-1:1], pend_nd};
        else                         buf_q[pend_fld] <= ram_rdata;
      end
      if (done) busy_q <= 1'b0;
      if (cpu_we && !busy_q) begin
        if (cpu_reg == 3'(REG_MASK)) begin
          mask_q <= cpu_wdata[7:0];
        end else if (cpu_reg == 3'(REG_REQ)) begin
          if (obj_ok) begin
            obj_q  <= req_obj;
            busy_q <= 1'b1;
            rem_q  <= mask_q[NFLD-1:0];
          end
        end else begin
          buf_q[FW'(cpu_reg)] <= cpu_wdata;
        end
      end
    end
  end
endmodule

// File: rtl/msgbuf_xfer_if.sv
`timescale 1ns/1ps
module msgbuf_xfer_if
  import msgbuf_pkg::*;
#(
  parameter int NUM_OBJ = 16,
  localparam int AW = $clog2(NUM_OBJ * NFLD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr,
  input  logic             cpu_set,
  input  logic [2:0]       cpu_reg,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  input  logic             ps_req,
  input  logic             ps_we,
  input  logic [AW-1:0]    ps_addr,
  input  logic [DW-1:0]    ps_wdata,
  output logic [DW-1:0]    ps_rdata,
  input  logic             ps_nd_set,
  input  logic [OBJ_W-1:0] ps_nd_obj
);
  localparam int DEPTH = NUM_OBJ * NFLD;
  localparam int OIW   = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1;

  logic [NSET-1:0]  set_busy;
  logic [NSET-1:0]  set_gnt;
  logic [NSET-1:0]  set_req;
  logic [NSET-1:0]  set_dir;
  logic [NSET-1:0]  set_clr;
  logic [NSET-1:0]  set_nd;
  logic [FW-1:0]    set_fld [NSET];
  logic [OBJ_W-1:0] set_obj [NSET];
  logic [DW-1:0]    set_wr  [NSET];
  logic [DW-1:0]    set_rd  [NSET];

  logic             ram_we;
  logic [AW-1:0]    ram_addr;
  logic [DW-1:0]    ram_wd;
  logic [DW-1:0]    ram_rd;
  logic [NUM_OBJ-1:0] nd_q;

  function automatic logic [OIW-1:0] nd_idx(input logic [OBJ_W-1:0] o);
    nd_idx = OIW'(o - OBJ_W'(1));
  endfunction

  function automatic logic [AW-1:0] obj_addr(input logic [OBJ_W-1:0] o, input logic [FW-1:0] f);
    obj_addr = AW'((int'(o) - 1) * NFLD + int'(f));
  endfunction

  for (genvar g = 0; g < NSET; g++) begin : g_set
    assign set_nd[g] = nd_q[nd_idx(set_obj[g])];
    msgbuf_ifset #(.NUM_OBJ(NUM_OBJ)) u_set (
      .clk       (clk),
      .rst       (rst),
      .cpu_we    (cpu_wr && (cpu_set == 1'(g))),
      .cpu_reg   (cpu_reg),
      .cpu_wdata (cpu_wdata),
      .rd_word   (set_rd[g]),
      .gnt       (set_gnt[g]),
      .ram_rdata (ram_rd),
      .nd_flag   (set_nd[g]),
      .req       (set_req[g]),
      .cur_fld   (set_fld[g]),
      .obj       (set_obj[g]),
      .dir       (set_dir[g]),
      .wr_word   (set_wr[g]),
      .clr_nd    (set_clr[g]),
      .busy      (set_busy[g])
    );
  end

  msgbuf_arb #(.NREQ(NSET)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .ps_req (ps_req),
    .req    (set_req),
    .gnt    (set_gnt)
  );

  always_comb begin
    ram_we   = 1'b0;
    ram_addr = ps_addr;
    ram_wd   = ps_wdata;
    if (ps_req) begin
      ram_we = ps_we;
    end else begin
      for (int i = 0; i < NSET; i++) begin
        if (set_gnt[i]) begin
          ram_we   = set_dir[i];
          ram_addr = obj_addr(set_obj[i], set_fld[i]);
          ram_wd   = set_wr[i];
        end
      end
    end
  end

  msgbuf_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wd),
    .rdata (ram_rd)
  );

  assign ps_rdata = ram_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      nd_q <= '0;
    end else begin
      for (int i = 0; i < NSET; i++) begin
        if (set_gnt[i] && set_dir[i] && (set_fld[i] == FW'(F_STAT)))
          nd_q[nd_idx(set_obj[i])] <= set_wr[i][0];
        if (set_clr[i]) nd_q[nd_idx(set_obj[i])] <= 1'b0;
      end
      if (ps_nd_set && (ps_nd_obj != '0) && (ps_nd_obj <= OBJ_W'(NUM_OBJ)))
        nd_q[nd_idx(ps_nd_obj)] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= set_rd[cpu_set];
  end
endmodule

// File: rtl/msgbuf_xfer_if_chk.sv
`timescale 1ns/1ps
module msgbuf_xfer_if_chk #(
  parameter int NUM_OBJ = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       ps_req,
  input logic       cpu_wr,
  input logic       cpu_set,
  input logic [2:0] cpu_reg,
  input logic [7:0] req_obj,
  input logic [1:0] set_busy,
  input logic [1:0] set_gnt
);
  logic obj_ok;
  assign obj_ok = (req_obj != 8'd0) && (req_obj <= 8'(NUM_OBJ));

  // R8: the protocol side wins every cycle it asks
  p_ps_first_r8: assert property (@(posedge clk) disable iff (rst)
    ps_req |-> (set_gnt == 2'b00));

  // R8: only one set drives the RAM port
  p_one_set_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_gnt));

  for (genvar g = 0; g < 2; g++) begin : g_chk
    // R4: grants go only to a set with a transfer in flight
    p_gnt_busy_r4: assert property (@(posedge clk) disable iff (rst)
      set_gnt[g] |-> set_busy[g]);

    // R4: a valid request on an idle set starts a transfer
    p_start_r4: assert property (@(posedge clk) disable iff (rst)
      (cpu_wr && (cpu_set == 1'(g)) && (cpu_reg == 3'd7) && !set_busy[g] && obj_ok)
      |=> set_busy[g]);

    // R5: an invalid object number leaves the set idle
    p_invalid_r5: assert property (@(posedge clk) disable iff (rst)
      (cpu_wr && (cpu_set == 1'(g)) && (cpu_reg == 3'd7) && !set_busy[g] && !obj_ok)
      |=> !set_busy[g]);
  end
endmodule

bind msgbuf_xfer_if msgbuf_xfer_if_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ps_req   (ps_req),
  .cpu_wr   (cpu_wr),
  .cpu_set  (cpu_set),
  .cpu_reg  (cpu_reg),
  .req_obj  (cpu_wdata[7:0]),
  .set_busy (set_busy),
  .set_gnt  (set_gnt)
);

// File: tb/msgbuf_xfer_if_tb_top.sv
`timescale 1ns/1ps
module msgbuf_xfer_if_tb_top;
  localparam int NOBJ = 16;
  localparam int NF   = 6;
  localparam int AW   = $clog2(NOBJ * NF);
  localparam int NVEC = 9;

  // {set, mask, object, seed}
  localparam logic [48:0] VEC [NVEC] = '{
    {1'b0, 8'h7F, 8'd1,  32'h1111_0000},
    {1'b0, 8'h49, 8'd2,  32'h2222_0000},
    {1'b1, 8'h3F, 8'd1,  32'h0},
    {1'b1, 8'h06, 8'd2,  32'h0},
    {1'b0, 8'h60, 8'd3,  32'h3333_0000},
    {1'b1, 8'hA0, 8'd3,  32'h0},
    {1'b1, 8'h20, 8'd3,  32'h0},
    {1'b0, 8'h3F, 8'd16, 32'h0},
    {1'b1, 8'h7F, 8'd16, 32'h4444_0000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_wr = 1'b0;
  logic          cpu_set = 1'b0;
  logic [2:0]    cpu_reg = '0;
  logic [31:0]   cpu_wdata = '0;
  logic [31:0]   cpu_rdata;
  logic          ps_req = 1'b0;
  logic          ps_we = 1'b0;
  logic [AW-1:0] ps_addr = '0;
  logic [31:0]   ps_wdata = '0;
  logic [31:0]   ps_rdata;
  logic          ps_nd_set = 1'b0;
  logic [7:0]    ps_nd_obj = '0;

  int total = 0;
  int bad   = 0;

  logic [31:0] mdl_ram [NOBJ+1][NF];
  logic [31:0] mdl_buf [2][NF];
  logic        mdl_nd  [NOBJ+1];

  always #2.5 clk = ~clk;

  msgbuf_xfer_if #(.NUM_OBJ(NOBJ)) dut_i (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_set(cpu_set), .cpu_reg(cpu_reg),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ps_req(ps_req), .ps_we(ps_we),
    .ps_addr(ps_addr), .ps_wdata(ps_wdata), .ps_rdata(ps_rdata),
    .ps_nd_set(ps_nd_set), .ps_nd_obj(ps_nd_obj)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // all tasks are entered at a falling edge and return at a falling edge
  task automatic cpu_write(input int s, input int r, input logic [31:0] d);
    cpu_wr = 1'b1; cpu_set = 1'(s); cpu_reg = 3'(r); cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input int s, input int r, output logic [31:0] d);
    cpu_set = 1'(s); cpu_reg = 3'(r);
    @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic ps_write(input int o, input int f, input logic [31:0] d);
    ps_req = 1'b1; ps_we = 1'b1; ps_addr = AW'((o - 1) * NF + f); ps_wdata = d;
    @(negedge clk);
    ps_req = 1'b0; ps_we = 1'b0;
  endtask

  task automatic ps_read(input int o, input int f, output logic [31:0] d);
    ps_req = 1'b1; ps_we = 1'b0; ps_addr = AW'((o - 1) * NF + f);
    @(negedge clk);
    ps_req = 1'b0;
    d = ps_rdata;
  endtask

  task automatic wait_idle(input int s, output int n);
    logic [31:0] r;
    n = 0;
    do begin
      cpu_read(s, 7, r);
      n++;
    end while (r[31] && n < 300);
    chk(!r[31], "R4 busy clears", r, {1'b0, r[30:0]});
  endtask

  task automatic model_xfer(input int s, input logic [7:0] m, input int o);
    for (int f = 0; f < NF; f++) begin
      if (m[f]) begin
        if (m[6]) begin
          mdl_ram[o][f] = mdl_buf[s][f];
          if (f == 5) mdl_nd[o] = mdl_buf[s][f][0];
        end else begin
          mdl_buf[s][f] = (f == 5) ? {mdl_ram[o][f][31:1], mdl_nd[o]} : mdl_ram[o][f];
        end
      end
    end
    if (!m[6] && m[7]) mdl_nd[o] = 1'b0;
  endtask

  task automatic cmp_bufs(input int s, input string tag);
    logic [31:0] r;
    for (int f = 0; f < NF; f++) begin
      cpu_read(s, f, r);
      chk(r == mdl_buf[s][f], tag, r, mdl_buf[s][f]);
    end
  endtask

  task automatic cmp_obj(input int o, input string tag);
    logic [31:0] r;
    for (int f = 0; f < NF; f++) begin
      ps_read(o, f, r);
      chk(r == mdl_ram[o][f], tag, r, mdl_ram[o][f]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R4 watchdog expired act=%h exp=%h", 32'h1, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n;
    for (int o = 0; o <= NOBJ; o++) mdl_nd[o] = 1'b0;
    for (int s = 0; s < 2; s++) for (int f = 0; f < NF; f++) mdl_buf[s][f] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(cpu_rdata == 32'h0, "R1 cpu_rdata", cpu_rdata, 32'h0);
    for (int s = 0; s < 2; s++) begin
      for (int g = 0; g < 8; g++) begin
        cpu_read(s, g, r);
        chk(r == 32'h0, "R1 reset register", r, 32'h0);
      end
    end

    // fill RAM through the protocol port
    for (int o = 1; o <= NOBJ; o++) begin
      for (int f = 0; f < NF; f++) begin
        mdl_ram[o][f] = 32'hA000_0000 | (o << 8) | f;
        ps_write(o, f, mdl_ram[o][f]);
      end
    end
    cmp_obj(16, "R11 protocol readback");

    // vector table: R2 writes, R3 reads, R9 flag path
    for (int v = 0; v < NVEC; v++) begin
      int s;
      logic [7:0] m;
      int o;
      logic [31:0] sd;
      s  = int'(VEC[v][48]);
      m  = VEC[v][47:40];
      o  = int'(VEC[v][39:32]);
      sd = VEC[v][31:0];
      if (m[6]) begin
        for (int f = 0; f < NF; f++) begin
          mdl_buf[s][f] = sd + 32'(f);
          cpu_write(s, f, mdl_buf[s][f]);
        end
      end
      cpu_write(s, 6, {24'h0, m});
      cpu_write(s, 7, 32'(o));
      wait_idle(s, n);
      model_xfer(s, m, o);
      if (m[6]) begin
        cmp_bufs(s, "R2 buffers kept");
        cmp_obj(o, "R2 RAM fields");
      end else begin
        cmp_bufs(s, "R3 R9 read buffers");
      end
    end

    // R7: neither set disturbed the other
    cmp_bufs(0, "R7 set 0 buffers");
    cmp_bufs(1, "R7 set 1 buffers");

    // R10: uncontended 6-field write, one word per clock
    cpu_write(0, 6, 32'h7F);
    cpu_write(0, 7, 32'd7);
    cpu_read(0, 7, r);
    chk(r == 32'h8000_0007, "R4 busy after request", r, 32'h8000_0007);
    n = 1;
    while (r[31] && n < 300) begin
      cpu_read(0, 7, r);
      n++;
    end
    chk(n <= NF + 2, "R10 completion time", 32'(n), 32'(NF + 2));
    model_xfer(0, 8'h7F, 7);
    cmp_obj(7, "R10 RAM fields");

    // R6 and R8: stall both sets behind the protocol side
    for (int f = 0; f < NF; f++) begin
      mdl_buf[1][f] = 32'h5151_0000 + 32'(f);
      cpu_write(1, f, mdl_buf[1][f]);
    end
    cpu_write(1, 6, 32'h7F);
    mdl_buf[0][0] = 32'h0A0A_0A0A;
    cpu_write(0, 0, mdl_buf[0][0]);
    cpu_write(0, 6, 32'h41);
    ps_req = 1'b1; ps_we = 1'b0; ps_addr = '0;
    cpu_write(1, 7, 32'd4);
    cpu_write(0, 7, 32'd5);
    cpu_write(0, 0, 32'hDEAD_BEEF);
    cpu_write(0, 6, 32'h7F);
    cpu_write(0, 7, 32'd6);
    repeat (5) @(negedge clk);
    cpu_read(0, 7, r);
    chk(r == 32'h8000_0005, "R8 set 0 stalled R6 request ignored", r, 32'h8000_0005);
    cpu_read(1, 7, r);
    chk(r == 32'h8000_0004, "R8 set 1 stalled", r, 32'h8000_0004);
    cpu_read(0, 6, r);
    chk(r == 32'h41, "R6 mask write ignored", r, 32'h41);
    cpu_read(0, 0, r);
    chk(r == 32'h0A0A_0A0A, "R6 buffer write ignored", r, 32'h0A0A_0A0A);
    ps_req = 1'b0;
    wait_idle(0, n);
    cpu_read(1, 7, r);
    chk(r[31] == 1'b1, "R8 set 0 served before set 1", {31'h0, r[31]}, 32'h1);
    wait_idle(1, n);
    model_xfer(0, 8'h41, 5);
    model_xfer(1, 8'h7F, 4);
    cmp_obj(5, "R6 R8 object 5");
    cmp_obj(4, "R8 object 4");
    cmp_obj(6, "R6 object 6 untouched");

    // R9: flag set from protocol side, read, cleared by option
    ps_nd_set = 1'b1; ps_nd_obj = 8'd9;
    @(negedge clk);
    ps_nd_set = 1'b0;
    mdl_nd[9] = 1'b1;
    cpu_write(0, 6, 32'h20);
    cpu_write(0, 7, 32'd9);
    wait_idle(0, n);
    model_xfer(0, 8'h20, 9);
    cpu_read(0, 5, r);
    chk(r == {mdl_ram[9][5][31:1], 1'b1}, "R9 flag seen set", r, {mdl_ram[9][5][31:1], 1'b1});
    cpu_write(0, 6, 32'h80);
    cpu_write(0, 7, 32'd9);
    wait_idle(0, n);
    model_xfer(0, 8'h80, 9);
    cpu_write(0, 6, 32'h20);
    cpu_write(0, 7, 32'd9);
    wait_idle(0, n);
    model_xfer(0, 8'h20, 9);
    cpu_read(0, 5, r);
    chk(r == {mdl_ram[9][5][31:1], 1'b0}, "R9 flag cleared", r, {mdl_ram[9][5][31:1], 1'b0});

    // R5: invalid object numbers
    cpu_write(0, 7, 32'd0);
    cpu_read(0, 7, r);
    chk(r == 32'h0000_0009, "R5 object 0", r, 32'h0000_0009);
    cpu_write(1, 7, 32'(NOBJ + 1));
    cpu_read(1, 7, r);
    chk(r == 32'h0000_0004, "R5 object above range", r, 32'h0000_0004);
    repeat (3) @(negedge clk);
    cpu_read(1, 7, r);
    chk(r == 32'h0000_0004, "R5 still idle", r, 32'h0000_0004);
    cmp_bufs(1, "R5 buffers unchanged");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule